// File: doc/BRIEF.md
# Cross-Clock Timer Register Shadow Updater

This block sits between a CPU bus running on the system clock and five timer registers that live in a timer clock domain: a counter value, two compare values and two control bytes. The timer clock can come from the I/O clock or from an asynchronous oscillator input. In synchronous mode a CPU write lands directly in the target register. In asynchronous mode the write is parked in a per-register holding register and that register's busy flag rises. A toggle handshake, with two-flop synchronizers in each direction, moves the value into the timer domain. The flag then drops, and software polls it to learn when the register can take another value.

A sixth bus address holds the mode: a clock-select bit and an external-clock enable. The external-clock enable must be set before asynchronous mode is entered. From the mode the block drives two enables: one for the crystal amplifier and one for the external clock input buffer. The clock multiplexer itself sits outside the block. It is driven from `async_sel`. Switching the clock source leaves the timer register contents undefined, so software rewrites them after a switch.

Top module: `xsr_shadow_updater`

## Requirements
- R1: After reset all busy flags are 0, all five target registers are 0, `async_sel`, `xtal_en` and `ext_in_en` are 0.
- R2: With `async_sel`=0, a write to address 0..4 (0 counter, 1 compare A, 2 compare B, 3 control A, 4 control B) loads that target on the same clock edge, and every busy flag stays 0.
- R3: With `async_sel`=1, an accepted write to address i sets `busy[i]` on the next system clock edge and no other busy bit.
- R4: In asynchronous mode the written value appears in target i within three timer clock edges after the write edge.
- R5: `busy[i]` returns to 0 within two system clock edges after target i has been updated.
- R6: A write to address i while `busy[i]` is 1 is ignored: the target ends with the first value.
- R7: Address 5 is the mode register: `wr_data[0]` is the clock select (1 = asynchronous), `wr_data[1]` the external-clock enable. The enable bit keeps its value on any mode write made while `async_sel` is already 1.
- R8: `xtal_en` = `async_sel` AND NOT enable, and `ext_in_en` = `async_sel` AND enable. The two are never 1 together.
- R9: A mode write that would change `async_sel` is ignored while any busy flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System (CPU / I/O) clock |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| clk_tmr | input | 1 | Timer clock, already multiplexed outside from `async_sel` |
| rst_tmr | input | 1 | Synchronous active-high reset, timer domain |
| wr_en | input | 1 | CPU write strobe, one system cycle |
| wr_addr | input | 3 | Register address: 0..4 targets, 5 mode |
| wr_data | input | 8 | Write data |
| busy | output | 5 | Per-register transfer-pending flags, bit i for address i |
| tgt_flat | output | 40 | Target registers, address i in bits [8i+7:8i] |
| async_sel | output | 1 | Clock select: 1 = asynchronous oscillator |
| xtal_en | output | 1 | Crystal amplifier enable |
| ext_in_en | output | 1 | External clock input buffer enable |

## Verification
Suppose the request or acknowledge toggles fall out of step. A busy flag then stays high forever or never rises, and this shows within a few system cycles of the write. A lane that reloads from a stale holding register shows up at the target once the flag clears, for example when a write made while busy gets through. A wrong mode lock is visible at once in the clock enables or in `async_sel` on the cycle after the mode write.

// File: rtl/xsr_pkg.sv
package xsr_pkg;

    localparam int DATA_W = 8;
    localparam int NREG   = 5;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT = 3'd0,
        SEL_CMP_A = 3'd1,
        SEL_CMP_B = 3'd2,
        SEL_CTL_A = 3'd3,
        SEL_CTL_B = 3'd4,
        SEL_MODE  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic ext_en;
        logic async_on;
    } mode_t;

    // Enable bit frozen while asynchronous; select frozen while transfers pend.
    function automatic mode_t mode_next(mode_t cur, logic [1:0] req, logic any_busy);
        mode_t n;
        n.ext_en   = cur.async_on ? cur.ext_en : req[1];
        n.async_on = (any_busy && (req[0] != cur.async_on)) ? cur.async_on : req[0];
        return n;
    endfunction

endpackage

// File: rtl/xsr_sync2.sv
module xsr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/xsr_lane.sv
module xsr_lane #(
    parameter int DW = xsr_pkg::DATA_W
) (
    input  logic          clk_sys,
    input  logic          rst_sys,
    input  logic          clk_tmr,
    input  logic          rst_tmr,
    input  logic          async_on,
    input  logic          hit,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic [DW-1:0] tgt_q
);
    logic [DW-1:0] hold_q;
    logic          req_t, req_s, ack_t, ack_s;

    // System side: holding register and request toggle.
    always_ff @(posedge clk_sys) begin
        if (rst_sys) begin
            hold_q <= '0;
            req_t  <= 1'b0;
        end else if (hit && async_on && !busy) begin
            hold_q <= wdata;
            req_t  <= ~req_t;
        end
    end

    xsr_sync2 #(.W(1)) u_req_sync (.clk(clk_tmr), .rst(rst_tmr), .d(req_t), .q(req_s));
    xsr_sync2 #(.W(1)) u_ack_sync (.clk(clk_sys), .rst(rst_sys), .d(ack_t), .q(ack_s));

    assign busy = req_t ^ ack_s;

    // Timer side: load from the holding register, or write directly when synchronous.
    always_ff @(posedge clk_tmr) begin
        if (rst_tmr) begin
            tgt_q <= '0;
            ack_t <= 1'b0;
        end else if (req_s != ack_t) begin
            tgt_q <= hold_q;
            ack_t <= req_s;
        end else if (hit && !async_on) begin
            tgt_q <= wdata;
        end
    end
endmodule

// File: rtl/xsr_mode_reg.sv
module xsr_mode_reg (
    input  logic           clk_sys,
    input  logic           rst_sys,
    input  logic           wr,
    input  logic [1:0]     req,
    input  logic           any_busy,
    output xsr_pkg::mode_t mode_q
);
    always_ff @(posedge clk_sys) begin
        if (rst_sys)  mode_q <= '0;
        else if (wr)  mode_q <= xsr_pkg::mode_next(mode_q, req, any_busy);
    end
endmodule

// File: rtl/xsr_shadow_updater.sv
module xsr_shadow_updater
    import xsr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = NREG,
    parameter int AW = ADDR_W
) (
    input  logic             clk_sys,
    input  logic             rst_sys,
    input  logic             clk_tmr,
    input  logic             rst_tmr,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [NR-1:0]    busy,
    output logic [NR*DW-1:0] tgt_flat,
    output logic             async_sel,
    output logic             xtal_en,
    output logic             ext_in_en
);
    mode_t mode_q;

    xsr_mode_reg u_mode (
        .clk_sys  (clk_sys),
        .rst_sys  (rst_sys),
        .wr       (wr_en && (wr_addr == AW'(SEL_MODE))),
        .req      (wr_data[1:0]),
        .any_busy (|busy),
        .mode_q   (mode_q)
    );

    assign async_sel = mode_q.async_on;
    assign xtal_en   = mode_q.async_on && !mode_q.ext_en;
    assign ext_in_en = mode_q.async_on &&  mode_q.ext_en;

    for (genvar i = 0; i < NR; i++) begin : g_lane
        xsr_lane #(.DW(DW)) u_lane (
            .clk_sys  (clk_sys),
            .rst_sys  (rst_sys),
            .clk_tmr  (clk_tmr),
            .rst_tmr  (rst_tmr),
            .async_on (mode_q.async_on),
            .hit      (wr_en && (wr_addr == AW'(i))),
            .wdata    (wr_data),
            .busy     (busy[i]),
            .tgt_q    (tgt_flat[i*DW +: DW])
        );
    end
endmodule

// File: rtl/xsr_shadow_updater_chk.sv
module xsr_shadow_updater_chk #(
    parameter int NR = xsr_pkg::NREG,
    parameter int AW = xsr_pkg::ADDR_W,
    parameter int DW = xsr_pkg::DATA_W
) (
    input logic          clk_sys,
    input logic          rst_sys,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [NR-1:0] busy,
    input logic          async_sel,
    input logic          xtal_en,
    input logic          ext_in_en
);
    p_sync_idle_r2: assert property (@(posedge clk_sys) disable iff (rst_sys)
        !async_sel |-> (busy == '0));

    for (genvar i = 0; i < NR; i++) begin : g_lane_chk
        p_busy_set_r3: assert property (@(posedge clk_sys) disable iff (rst_sys)
            (async_sel && wr_en && wr_addr == AW'(i) && !busy[i]) |=> busy[i]);
    end

    p_one_new_flag_r3: assert property (@(posedge clk_sys) disable iff (rst_sys)
        $onehot0(busy & ~$past(busy)));

    p_ext_locked_r7: assert property (@(posedge clk_sys) disable iff (rst_sys)
        (async_sel && wr_en && wr_addr == AW'(xsr_pkg::SEL_MODE) && wr_data[0])
        |=> (ext_in_en == $past(ext_in_en)));

    p_enables_excl_r8: assert property (@(posedge clk_sys) disable iff (rst_sys)
        !(xtal_en && ext_in_en));

    p_enables_off_r8: assert property (@(posedge clk_sys) disable iff (rst_sys)
        !async_sel |-> (!xtal_en && !ext_in_en));

    p_sel_locked_r9: assert property (@(posedge clk_sys) disable iff (rst_sys)
        (busy != '0) |=> (async_sel == $past(async_sel)));
endmodule

bind xsr_shadow_updater xsr_shadow_updater_chk #(.NR(NR), .AW(AW), .DW(DW)) u_chk (
    .clk_sys   (clk_sys),
    .rst_sys   (rst_sys),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .async_sel (async_sel),
    .xtal_en   (xtal_en),
    .ext_in_en (ext_in_en)
);

// File: tb/tb_xsr_shadow_updater.sv
module tb_xsr_shadow_updater;
    localparam int DW = 8;
    localparam int NR = 5;

    logic clk_sys = 1'b0, clk_osc = 1'b0;
    logic rst_sys = 1'b1, rst_tmr = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NR-1:0] busy;
    logic [NR*DW-1:0] tgt_flat;
    logic async_sel, xtal_en, ext_in_en, clk_tmr;

    int total = 0, bad = 0;

    always #5 clk_sys = ~clk_sys;
    initial begin #3; forever #17 clk_osc = ~clk_osc; end
    assign clk_tmr = async_sel ? clk_osc : clk_sys;

    xsr_shadow_updater dut (
        .clk_sys(clk_sys), .rst_sys(rst_sys), .clk_tmr(clk_tmr), .rst_tmr(rst_tmr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .tgt_flat(tgt_flat), .async_sel(async_sel), .xtal_en(xtal_en), .ext_in_en(ext_in_en)
    );

    // {addr, data}
    localparam logic [10:0] VEC [6] = '{
        {3'd0, 8'h5A}, {3'd1, 8'hC3}, {3'd2, 8'hFF},
        {3'd3, 8'h01}, {3'd4, 8'h80}, {3'd0, 8'h00}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk_sys);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_sys);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] tgt(input int a);
        return tgt_flat[a*DW +: DW];
    endfunction

    // After an async write: wait for the target and the busy clear, check bounds.
    task automatic wait_xfer(input int a, input logic [7:0] d, input string tag);
        int t_at = -1, b_at = -1;
        for (int n = 1; n <= 30; n++) begin
            if (t_at < 0 && tgt(a) == d) t_at = n;
            if (b_at < 0 && busy[a] == 1'b0) b_at = n;
            if (t_at >= 0 && b_at >= 0) break;
            @(negedge clk_sys);
        end
        chk(t_at >= 0 && t_at <= 12, {tag, " R4 target latency"}, t_at, 12);
        chk(b_at >= 0 && b_at >= t_at && b_at - t_at <= 3, {tag, " R5 busy clear"}, b_at, t_at + 2);
    endtask

    initial begin
        repeat (4) @(negedge clk_sys);
        rst_sys = 1'b0; rst_tmr = 1'b0;
        @(negedge clk_sys);
        // R1 reset state
        chk(busy == '0 && tgt_flat == '0, "R1 reset regs", int'(tgt_flat[31:0]), 0);
        chk(!async_sel && !xtal_en && !ext_in_en, "R1 reset mode", {async_sel, xtal_en, ext_in_en}, 0);

        // R2 synchronous table walk
        foreach (VEC[k]) begin
            cpu_wr(VEC[k][10:8], VEC[k][7:0]);
            chk(tgt(VEC[k][10:8]) == VEC[k][7:0], "R2 direct load", tgt(VEC[k][10:8]), VEC[k][7:0]);
            chk(busy == '0, "R2 busy idle", busy, 0);
        end

        // Enter asynchronous mode with the crystal (R7/R8)
        cpu_wr(3'd5, 8'h01);
        chk(async_sel && xtal_en && !ext_in_en, "R8 crystal enable", {async_sel, xtal_en, ext_in_en}, 3'b110);

        // R3/R4/R5 asynchronous table walk (inverted data)
        foreach (VEC[k]) begin
            cpu_wr(VEC[k][10:8], ~VEC[k][7:0]);
            chk(busy == NR'(1) << VEC[k][10:8], "R3 own flag", busy, NR'(1) << VEC[k][10:8]);
            wait_xfer(VEC[k][10:8], ~VEC[k][7:0], "table");
        end

        // R6 write while busy is ignored
        cpu_wr(3'd2, 8'h11);
        cpu_wr(3'd2, 8'h22);
        wait_xfer(2, 8'h11, "R6");
        repeat (12) @(negedge clk_sys);
        chk(tgt(2) == 8'h11, "R6 second write dropped", tgt(2), 8'h11);

        // R9 select change blocked while a flag is set
        cpu_wr(3'd3, 8'h3C);
        cpu_wr(3'd5, 8'h00);
        chk(async_sel == 1'b1, "R9 select held", async_sel, 1);
        wait_xfer(3, 8'h3C, "R9");

        // Back to sync, then set external enable before async (R7/R8)
        cpu_wr(3'd5, 8'h00);
        chk(!async_sel && !xtal_en && !ext_in_en, "R8 sync enables off", {async_sel, xtal_en, ext_in_en}, 0);
        cpu_wr(3'd5, 8'h02);
        chk(!async_sel && !ext_in_en, "R8 ext staged", {async_sel, ext_in_en}, 0);
        cpu_wr(3'd5, 8'h03);
        chk(ext_in_en && !xtal_en, "R8 ext buffer on", {xtal_en, ext_in_en}, 1);
        // R7 clearing the enable while async is ignored
        cpu_wr(3'd5, 8'h01);
        chk(ext_in_en && !xtal_en && async_sel, "R7 ext locked", {async_sel, xtal_en, ext_in_en}, 3'b101);

        // Transfer still works on the external clock path
        cpu_wr(3'd4, 8'h9D);
        chk(busy == 5'b10000, "R3 flag on ctl B", busy, 5'b10000);
        wait_xfer(4, 8'h9D, "ext");

        // R7 enable stays through leaving async; re-entering with req bit1=0 picks crystal
        cpu_wr(3'd5, 8'h00);
        cpu_wr(3'd5, 8'h01);
        chk(xtal_en && !ext_in_en, "R7 enable rewritten when sync", {xtal_en, ext_in_en}, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule